// File: doc/BRIEF.md
# Audio Capture Ring-Buffer Writer

This block sits between up to three audio capture ports and a memory write port. It takes 32-bit capture words from the port picked by a source select. From each word it keeps one bit field, bounded by a programmable top bit and bottom bit. The kept fields are packed back to back into 64-bit lines, and each finished line goes into an internal FIFO.

When the number of lines in the FIFO reaches a programmable threshold, the block starts a burst of exactly that many 64-bit writes. Each write goes through a request/acknowledge port. The write address walks through a circular buffer. The buffer is set by a start address and an inclusive finish address, both of which point at 64-bit words. The block also has three controls:
- a force-restart pulse, which makes the next write go to the start address;
- a sticky overrun flag for a FIFO that has overflowed;
- a position output that shows where the next write will land.

Top module: `capture_ring_writer`

## Requirements
- R1: After reset, `wr_req` and `overrun` are low, and from the first clock edge after reset release `cur_addr` equals `start_addr`.
- R2: From each accepted word, bits `fld_msb` down to `fld_lsb` are kept, with width W = msb-lsb+1, from 1 to 32. Fields are packed starting at bit 0 of a line, each one directly above the previous. A field that crosses bit 63 continues at bit 0 of the next line.
- R3: `src_sel` value k (0, 1 or 2) takes words only from `in_valid[k]` with `in_data[32k+31:32k]`. Value 3 takes no words at all.
- R4: No write is requested while the FIFO holds fewer lines than `fill_thresh`, where 0 is treated as 1. Once it holds at least that many, a burst of exactly `fill_thresh` writes is requested, in FIFO order.
- R5: While `wr_req` is high and `wr_ack` is low, `wr_addr` and `wr_data` stay stable. Each acknowledged write moves the address up by 8.
- R6: The write after the one at `finish_addr` goes to `start_addr`. This includes a ring of a single word, where `finish_addr` equals `start_addr`.
- R7: After a `force_restart` pulse, the next write goes to `start_addr`. If a write is pending, it completes at its own address first.
- R8: When a finished line finds the FIFO full, the line is lost and `overrun` is set. `overrun` stays set until `overrun_clr`, and every word that arrives while it is set is dropped.
- R9: While `enable` is low, words are ignored, the partial line is discarded, and no new burst starts.
- R10: `cur_addr` shows the address of the next write. After a burst has drained, it is the address that follows the last word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel run control |
| src_sel | input | 2 | Capture source select (0..2, 3 = none) |
| in_valid | input | 3 | Word strobe for each capture source |
| in_data | input | 96 | Capture words, source k in bits 32k+31:32k |
| fld_msb | input | 5 | Top bit of the kept field |
| fld_lsb | input | 5 | Bottom bit of the kept field |
| fill_thresh | input | 8 | FIFO lines that trigger a burst; also the burst length |
| start_addr | input | 32 | First 64-bit word of the ring |
| finish_addr | input | 32 | Last 64-bit word of the ring, inclusive |
| force_restart | input | 1 | Pulse: next write goes to start_addr |
| overrun_clr | input | 1 | Clears the overrun flag |
| overrun | output | 1 | Sticky FIFO overflow flag |
| cur_addr | output | 32 | Address of the next write |
| wr_req | output | 1 | Write request |
| wr_ack | input | 1 | Write acknowledge |
| wr_addr | output | 32 | Write address |
| wr_data | output | 64 | Write data |

## Verification
Random capture words, with random strobes on the unselected ports, are packed at field widths of 16, 24, 7, 1 and 32 bits:
- Width 16 divides a line evenly. Widths 24 and 7 make fields cross line boundaries, which shows whether carry-over is handled correctly. Widths 1 and 32 test the two ends of the mask and shift range.
- The acknowledge is random, so each write is held for a different number of cycles.
- Rings of twelve words and of one word separate ordinary stepping from wrap.
- Directed runs use several stimuli to expose a trigger that fires early, a source leak, a packer that is not cleared, and any word that leaks through while the block should be dropping input:
  - an unacknowledged stream stopped one line short of the threshold;
  - a disabled channel and a channel with no source;
  - a fill past FIFO capacity.

// File: rtl/capture_ring_writer.sv
module capture_ring_writer #(
  parameter int DEPTH = 128,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    src_sel,
  input  logic [2:0]    in_valid,
  input  logic [95:0]   in_data,
  input  logic [4:0]    fld_msb,
  input  logic [4:0]    fld_lsb,
  input  logic [$clog2(DEPTH+1)-1:0] fill_thresh,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] finish_addr,
  input  logic          force_restart,
  input  logic          overrun_clr,
  output logic          overrun,
  output logic [AW-1:0] cur_addr,
  output logic          wr_req,
  input  logic          wr_ack,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic        s_vld;
  logic [31:0] s_dat;
  always_comb begin
    s_vld = 1'b0;
    s_dat = '0;
    case (src_sel)
      2'd0: begin s_vld = in_valid[0]; s_dat = in_data[31:0];  end
      2'd1: begin s_vld = in_valid[1]; s_dat = in_data[63:32]; end
      2'd2: begin s_vld = in_valid[2]; s_dat = in_data[95:64]; end
      default: ;
    endcase
  end

  logic [5:0]  fw;
  logic [31:0] mask, fld;
  logic [95:0] acc, acc_n;
  logic [6:0]  cnt, cnt_n;
  logic        accept, line_rdy;

  assign fw       = {1'b0, fld_msb} - {1'b0, fld_lsb} + 6'd1;
  assign mask     = 32'hFFFF_FFFF >> (6'd32 - fw);
  assign fld      = (s_dat >> fld_lsb) & mask;
  assign accept   = enable && s_vld && !overrun;
  assign acc_n    = acc | ({64'd0, fld} << cnt);
  assign cnt_n    = cnt + {1'b0, fw};
  assign line_rdy = accept && (cnt_n >= 7'd64);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      acc <= '0;
      cnt <= '0;
    end else if (accept) begin
      if (line_rdy) begin
        acc <= acc_n >> 64;
        cnt <= cnt_n - 7'd64;
      end else begin
        acc <= acc_n;
        cnt <= cnt_n;
      end
    end
  end

  logic [63:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill, left, thr_eff;
  logic          full, push, pop, ovf;

  assign full = (fill == CW'(DEPTH));
  assign push = line_rdy && !full;
  assign ovf  = line_rdy && full;
  assign pop  = wr_req && wr_ack;

  always_ff @(posedge clk)
    if (push) mem[wp] <= acc_n[63:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           overrun <= 1'b0;
    else if (overrun_clr) overrun <= 1'b0;
    else if (ovf)         overrun <= 1'b1;
  end

  assign thr_eff = (fill_thresh == '0) ? CW'(1) : fill_thresh;

  always_ff @(posedge clk) begin
    if (!rst_n)                           left <= '0;
    else if (left == '0) begin
      if (enable && fill >= thr_eff)      left <= thr_eff;
    end else if (pop)                     left <= left - 1'b1;
  end

  assign wr_req  = (left != '0);
  assign wr_data = mem[rp];

  logic [AW-1:0] addr;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      pend <= 1'b1;
    end else if (pop) begin
      addr <= (pend || force_restart || addr == finish_addr) ? start_addr : addr + AW'(8);
      pend <= 1'b0;
    end else if (!wr_req && (pend || force_restart)) begin
      addr <= start_addr;
      pend <= 1'b0;
    end else if (force_restart) begin
      pend <= 1'b1;
    end
  end

  assign wr_addr  = addr;
  assign cur_addr = addr;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !pend && !force_restart && wr_addr != finish_addr |=> cur_addr == $past(wr_addr) + AW'(8)); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pop && wr_addr == finish_addr |=> cur_addr == $past(start_addr)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !overrun_clr |=> overrun); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH) && (!wr_req || fill != '0)); // R4
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !wr_req |=> !wr_req); // R9
endmodule

// File: tb/tb_capture_ring_writer.sv
module tb_capture_ring_writer;
  localparam int DEPTH = 128;
  localparam logic [31:0] START = 32'h0000_1000;

  logic clk = 0, rst_n = 0, enable = 0, force_restart = 0, overrun_clr = 0, wr_ack = 0;
  logic [1:0]  src_sel = 0;
  logic [2:0]  in_valid = 0;
  logic [95:0] in_data = 0;
  logic [4:0]  fld_msb = 31, fld_lsb = 0;
  logic [7:0]  fill_thresh = 4;
  logic [31:0] start_addr = START, finish_addr = START + 32'd88;
  logic overrun, wr_req;
  logic [31:0] cur_addr, wr_addr;
  logic [63:0] wr_data;

  capture_ring_writer #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel), .in_valid(in_valid),
    .in_data(in_data), .fld_msb(fld_msb), .fld_lsb(fld_lsb), .fill_thresh(fill_thresh),
    .start_addr(start_addr), .finish_addr(finish_addr), .force_restart(force_restart),
    .overrun_clr(overrun_clr), .overrun(overrun), .cur_addr(cur_addr), .wr_req(wr_req),
    .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data));

  always #2 clk = ~clk;

  int errs = 0, checks = 0, req_cycles = 0;
  bit ack_en = 0;
  logic [31:0] la[$], ea[$];
  logic [63:0] ld[$], ed[$];
  logic [95:0] macc;
  int mcnt;
  logic [31:0] mptr;

  always @(negedge clk) begin
    if (wr_req) req_cycles++;
    wr_ack = ack_en && ($urandom % 4 != 0);
    if (wr_req && wr_ack) begin
      la.push_back(wr_addr);
      ld.push_back(wr_data);
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [31:0] model_field(logic [31:0] s);
    int w = int'(fld_msb) - int'(fld_lsb) + 1;
    logic [63:0] m = (64'h1 << w) - 64'h1;
    return 32'((64'(s) >> fld_lsb) & m);
  endfunction

  function automatic void model_push(logic [31:0] s);
    int w = int'(fld_msb) - int'(fld_lsb) + 1;
    macc = macc | (96'(model_field(s)) << mcnt);
    mcnt += w;
    if (mcnt >= 64) begin
      ea.push_back(mptr);
      ed.push_back(macc[63:0]);
      mptr = (mptr == finish_addr) ? start_addr : mptr + 32'd8;
      macc = macc >> 64;
      mcnt -= 64;
    end
  endfunction

  task automatic feed(int n, bit model);
    int got = 0;
    int cyc = 0;
    while (got < n) begin
      @(negedge clk);
      in_data  = {$urandom, $urandom, $urandom};
      in_valid = 3'($urandom);
      cyc++;
      if (src_sel == 2'd3) begin
        if (cyc >= n) got = n;
      end else if (in_valid[src_sel]) begin
        if (model) model_push(in_data[32*src_sel +: 32]);
        got++;
      end
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while (t < 20000 && !(la.size() == ea.size() && !wr_req)) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(la.size() == ea.size(), {req, " write count"}, 64'(la.size()), 64'(ea.size()));
    for (int i = 0; i < ea.size() && i < la.size(); i++) begin
      chk(la[i] == ea[i], {req, " write address"}, 64'(la[i]), 64'(ea[i]));
      chk(ld[i] == ed[i], {req, " write data"}, ld[i], ed[i]);
    end
    chk(cur_addr == mptr, "R10 position after drain", 64'(cur_addr), 64'(mptr));
    la.delete(); ld.delete(); ea.delete(); ed.delete();
  endtask

  task automatic setup(logic [1:0] s, logic [4:0] hi, logic [4:0] lo, logic [7:0] thr, logic [31:0] fin);
    @(negedge clk);
    enable = 0; src_sel = s; fld_msb = hi; fld_lsb = lo; fill_thresh = thr;
    finish_addr = fin; force_restart = 1;
    @(negedge clk);
    force_restart = 0; enable = 1;
    macc = 0; mcnt = 0; mptr = start_addr;
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int rc;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(wr_req == 0, "R1 wr_req after reset", 64'(wr_req), 0);
    chk(overrun == 0, "R1 overrun after reset", 64'(overrun), 0);
    chk(cur_addr == START, "R1 position after reset", 64'(cur_addr), 64'(START));
    ack_en = 1;

    // R2 R3 R5 R6: 16-bit fields, source 1, ring of 12 words
    setup(2'd1, 5'd31, 5'd16, 8'd4, START + 32'd88);
    feed(64, 1);
    drain("R2 R5 R6 width16");

    // R2 R7: 24-bit straddling fields, source 2, restart
    setup(2'd2, 5'd27, 5'd4, 8'd4, START + 32'd88);
    feed(32, 1);
    drain("R2 R7 width24");

    // R2 R6: 7-bit fields, single-word ring
    setup(2'd0, 5'd10, 5'd4, 8'd7, START);
    feed(64, 1);
    drain("R2 R6 width7 single-word ring");

    // R2: 1-bit fields
    setup(2'd1, 5'd0, 5'd0, 8'd4, START + 32'd88);
    feed(256, 1);
    drain("R2 width1");

    // R2: full 32-bit fields
    setup(2'd0, 5'd31, 5'd0, 8'd5, START + 32'd88);
    feed(40, 1);
    drain("R2 width32");

    // R4: threshold
    setup(2'd0, 5'd31, 5'd0, 8'd4, START + 32'd88);
    ack_en = 0;
    feed(6, 1);
    repeat (5) @(negedge clk);
    chk(wr_req == 0, "R4 no request below threshold", 64'(wr_req), 0);
    feed(2, 1);
    repeat (3) @(negedge clk);
    chk(wr_req == 1, "R4 request at threshold", 64'(wr_req), 1);
    chk(wr_addr == START, "R7 first write at start", 64'(wr_addr), 64'(START));
    ack_en = 1;
    drain("R4 burst");

    // R9: disabled channel
    setup(2'd0, 5'd31, 5'd0, 8'd1, START + 32'd88);
    @(negedge clk);
    enable = 0;
    rc = req_cycles;
    feed(40, 0);
    repeat (4) @(negedge clk);
    chk(req_cycles == rc, "R9 no request while disabled", 64'(req_cycles - rc), 0);
    enable = 1;
    fill_thresh = 2;
    feed(4, 1);
    drain("R9 after enable");

    // R3: no source selected
    setup(2'd3, 5'd31, 5'd0, 8'd1, START + 32'd88);
    rc = req_cycles;
    feed(40, 0);
    repeat (4) @(negedge clk);
    chk(req_cycles == rc, "R3 no request with source 3", 64'(req_cycles - rc), 0);
    @(negedge clk);
    src_sel = 2'd2;
    fill_thresh = 2;
    feed(4, 1);
    drain("R3 source 2 after none");

    // R8: overrun
    setup(2'd0, 5'd31, 5'd0, 8'd200, START + 32'd88);
    ack_en = 0;
    feed(2 * DEPTH, 1);
    chk(overrun == 0, "R8 no overrun at full", 64'(overrun), 0);
    feed(2, 0);
    repeat (2) @(negedge clk);
    chk(overrun == 1, "R8 overrun set", 64'(overrun), 1);
    feed(10, 0);
    chk(overrun == 1, "R8 overrun sticky", 64'(overrun), 1);
    overrun_clr = 1;
    @(negedge clk);
    overrun_clr = 0;
    @(negedge clk);
    chk(overrun == 0, "R8 overrun cleared", 64'(overrun), 0);
    fill_thresh = 8'd128;
    ack_en = 1;
    drain("R8 full FIFO contents");
    fill_thresh = 2;
    feed(4, 1);
    drain("R8 after clear");

    summary();
  end
endmodule